// File: doc/BRIEF.md
# Pipelined Signed 8x8 Array Multiplier

This block multiplies two 8-bit two's-complement operands and returns the exact 16-bit signed product. The sign is not handled by extending the operands. Instead, the partial products that involve exactly one operand sign bit are complemented, the product of the two sign bits stays true, and two constant ones are added, at column 8 and column 15. The eight partial-product rows are summed by a carry-save array with one register per row. A carry-propagate adder then resolves two result bits per registered stage. Operand bits that later rows still need, and sum and carry bits not yet resolved, travel with the data. As a result, every bit of a product leaves the block in the same cycle.

The pipeline never stalls. A new operand pair with `in_valid` high can be presented on every clock. Each product appears exactly 17 cycles later, with `out_valid` high in that same cycle. The active-low reset clears every valid bit in the pipeline but leaves the data registers as they are. Data registers load only when the valid bit beside them is high, so the product output holds its last value while no result is emerging.

Top module: `bwm_mult`

## Requirements
- R1: `product` equals the exact two's-complement product of `mult_a` and `mult_b`, read as signed 8-bit values, for any operand pair.
- R2: An operand pair sampled with `in_valid` high on clock edge n gives `out_valid` high and its product after edge n+16, and not after edge n+15.
- R3: Operand pairs presented on consecutive clocks are all accepted, and their products appear on consecutive clocks in the same order.
- R4: `out_valid` repeats the pattern of `in_valid` delayed by 17 cycles, gaps included.
- R5: While `rst_n` is low, `out_valid` is low. Operations in flight when reset is asserted never produce a valid output.
- R6: -128 x -128 gives +16384 (0x4000), and -1 x -1 gives +1.
- R7: -128 x 127 gives -16256, 127 x -128 gives -16256, and 127 x 127 gives 16129.
- R8: A zero operand gives a zero product regardless of the other operand.
- R9: In a cycle where `out_valid` is low, `product` keeps the last valid product. Operands presented with `in_valid` low have no effect on `product`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand pair is valid this cycle |
| mult_a | input | 8 | Signed multiplicand |
| mult_b | input | 8 | Signed multiplier |
| out_valid | output | 1 | Product is valid this cycle |
| product | output | 16 | Signed product |

## Verification
The bench targets the operand values at which the sign correction matters most. If one of the complemented sign terms were wrong, -128 x -128 would come out with the wrong sign. If a correction constant were dropped, 127 x -128 and -1 x -1 would be wrong. If a sign-bit row were mishandled, a zero operand would give a nonzero product. A misplaced alignment register would shift one operand's bits by a cycle relative to the other's. Long back-to-back streams of changing operands expose that as wrong products, and gapped streams expose a valid bit that arrives off by one cycle. A reset applied mid-stream catches a valid bit that survives reset. Changing the operands while `in_valid` is low catches data registers that load without their enable.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int OP_W   = 8;
  localparam int PROD_W = 2 * OP_W;

  // Data that moves through the carry-save rows.
  typedef struct packed {
    logic [OP_W-1:0]   a;
    logic [OP_W-1:0]   b;
    logic [PROD_W-1:0] s;
    logic [PROD_W-1:0] c;
  } csa_t;

  // Data that moves through the carry-propagate stages; resolved bits are written into s.
  typedef struct packed {
    logic [PROD_W-1:0] s;
    logic [PROD_W-1:0] c;
    logic              cy;
  } rip_t;

  function automatic int total_latency(input int rb);
    return 1 + OP_W + PROD_W / rb;
  endfunction
endpackage

// File: rtl/bwm_pp_row.sv
module bwm_pp_row
  import bwm_pkg::*;
#(
  parameter int ROW = 0
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [PROD_W-1:0] pp
);
  always_comb begin
    pp = '0;
    for (int i = 0; i < OP_W; i++) begin
      // complement when exactly one index is the sign position
      if ((i == OP_W-1) != (ROW == OP_W-1)) pp[i+ROW] = ~(a[i] & b[ROW]);
      else                                  pp[i+ROW] =   a[i] & b[ROW];
    end
  end
endmodule

// File: rtl/bwm_csa_stage.sv
module bwm_csa_stage
  import bwm_pkg::*;
#(
  parameter int ROW = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  csa_t d_i,
  output logic vld_o,
  output csa_t d_o
);
  logic [PROD_W-1:0] pp;
  logic [PROD_W-1:0] maj;
  csa_t              d_n;

  bwm_pp_row #(.ROW(ROW)) u_row (.a(d_i.a), .b(d_i.b), .pp(pp));

  always_comb begin
    maj    = (d_i.s & d_i.c) | (d_i.s & pp) | (d_i.c & pp);
    d_n.a  = d_i.a;
    d_n.b  = d_i.b;
    d_n.s  = d_i.s ^ d_i.c ^ pp;
    d_n.c  = {maj[PROD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (vld_i) d_o <= d_n;
  end
endmodule

// File: rtl/bwm_ripple_stage.sv
module bwm_ripple_stage
  import bwm_pkg::*;
#(
  parameter int IDX = 0,
  parameter int RB  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  rip_t d_i,
  output logic vld_o,
  output rip_t d_o
);
  localparam int LO = IDX * RB;

  logic [RB:0] sum;
  rip_t        d_n;

  always_comb begin
    sum = {1'b0, d_i.s[LO +: RB]} + {1'b0, d_i.c[LO +: RB]} + {{RB{1'b0}}, d_i.cy};
    d_n = d_i;
    d_n.s[LO +: RB] = sum[RB-1:0];
    d_n.cy = sum[RB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (vld_i) d_o <= d_n;
  end
endmodule

// File: rtl/bwm_mult.sv
module bwm_mult
  import bwm_pkg::*;
#(
  parameter int RIPPLE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   mult_a,
  input  logic [OP_W-1:0]   mult_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] product
);
  localparam int NRIP = PROD_W / RIPPLE_BITS;
  localparam logic [PROD_W-1:0] BW_CONST =
    (PROD_W'(1) << OP_W) | (PROD_W'(1) << (PROD_W-1));

  csa_t csa_d [0:OP_W];
  logic csa_v [0:OP_W];
  rip_t rip_d [0:NRIP];
  logic rip_v [0:NRIP];
  csa_t in_n;

  // input register: operands plus the sign-correction constant
  always_comb begin
    in_n.a = mult_a;
    in_n.b = mult_b;
    in_n.s = BW_CONST;
    in_n.c = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csa_v[0] <= 1'b0;
    else        csa_v[0] <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) csa_d[0] <= in_n;
  end

  for (genvar r = 0; r < OP_W; r++) begin : g_row
    bwm_csa_stage #(.ROW(r)) u_csa (
      .clk(clk), .rst_n(rst_n),
      .vld_i(csa_v[r]),   .d_i(csa_d[r]),
      .vld_o(csa_v[r+1]), .d_o(csa_d[r+1])
    );
  end

  always_comb begin
    rip_v[0]    = csa_v[OP_W];
    rip_d[0].s  = csa_d[OP_W].s;
    rip_d[0].c  = csa_d[OP_W].c;
    rip_d[0].cy = 1'b0;
  end

  for (genvar k = 0; k < NRIP; k++) begin : g_rip
    bwm_ripple_stage #(.IDX(k), .RB(RIPPLE_BITS)) u_rip (
      .clk(clk), .rst_n(rst_n),
      .vld_i(rip_v[k]),   .d_i(rip_d[k]),
      .vld_o(rip_v[k+1]), .d_o(rip_d[k+1])
    );
  end

  assign out_valid = rip_v[NRIP];
  assign product   = rip_d[NRIP].s;
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker
  import bwm_pkg::*;
#(
  parameter int RB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   mult_a,
  input logic [OP_W-1:0]   mult_b,
  input logic              out_valid,
  input logic [PROD_W-1:0] product
);
  localparam int LAT = total_latency(RB);

  logic [LAT-1:0]    vld_sh;
  logic [PROD_W-1:0] prod_sh [LAT];
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sh <= '0;
      armed  <= 1'b0;
    end else begin
      vld_sh <= {vld_sh[LAT-2:0], in_valid};
      armed  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    prod_sh[0] <= PROD_W'($signed(mult_a) * $signed(mult_b));
    for (int i = 1; i < LAT; i++) prod_sh[i] <= prod_sh[i-1];
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_sh[LAT-1]);

  a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == prod_sh[LAT-1]);

  a_r5_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  a_r9_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !out_valid) |-> $stable(product));
endmodule

bind bwm_mult bwm_checker #(.RB(RIPPLE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mult_a(mult_a),
  .mult_b(mult_b), .out_valid(out_valid), .product(product)
);

// File: tb/bwm_mult_test.sv
module bwm_mult_test;
  localparam int LAT = 17;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  mult_a;
  logic [7:0]  mult_b;
  logic        out_valid;
  logic [15:0] product;

  int          errors = 0;
  int          checks = 0;
  logic [15:0] last_exp = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 0;

  bwm_mult uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mult_a(mult_a),
    .mult_b(mult_b), .out_valid(out_valid), .product(product)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int ia = $signed(a);
    int ib = $signed(b);
    int p  = ia * ib;
    return p[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // R5: reset state
  task automatic test_reset();
    bit stayed_low = 1;
    rst_n = 1'b0; in_valid = 1'b0; mult_a = '0; mult_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (LAT + 3) begin
      @(negedge clk);
      if (out_valid) stayed_low = 0;
    end
    chk(stayed_low, "R5", "out_valid idle after reset", !stayed_low, 0);
  endtask

  // R2 latency plus one value check
  task automatic run_single(input logic [7:0] a, input logic [7:0] b, input string req);
    logic [15:0] e = ref_mul(a, b);
    @(negedge clk); mult_a = a; mult_b = b; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; mult_a = ~a; mult_b = ~b;
    repeat (15) @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid one cycle early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", "out_valid at 17 cycles", out_valid, 1);
    chk(product == e, req, "single product", $signed(product), $signed(e));
    last_exp = e;
  endtask

  task automatic test_corners();
    run_single(8'h80, 8'h80, "R6");
    run_single(8'hFF, 8'hFF, "R6");
    run_single(8'h80, 8'h7F, "R7");
    run_single(8'h7F, 8'h80, "R7");
    run_single(8'h7F, 8'h7F, "R7");
    run_single(8'h00, 8'hB3, "R8");
    run_single(8'h80, 8'h00, "R8");
    run_single(8'hFF, 8'h01, "R1");
  endtask

  // R1, R3, R4, R9: streamed operands, optional gaps
  task automatic run_stream(input int n, input bit gaps);
    logic [7:0]  qa [64];
    logic [7:0]  qb [64];
    logic        qv [64];
    for (int t = 0; t < n + LAT; t++) begin
      @(negedge clk);
      if (t >= LAT) begin
        int k = t - LAT;
        chk(out_valid == qv[k], "R4", "out_valid pattern", out_valid, qv[k]);
        if (qv[k]) begin
          logic [15:0] e = ref_mul(qa[k], qb[k]);
          chk(product == e, gaps ? "R1" : "R3", "stream product",
              $signed(product), $signed(e));
          last_exp = e;
        end else begin
          chk(product == last_exp, "R9", "product hold",
              $signed(product), $signed(last_exp));
        end
      end
      if (t < n) begin
        step_lfsr();
        qa[t] = lfsr[7:0];
        qb[t] = lfsr[15:8];
        if (t == 0) begin qa[t] = 8'h80; qb[t] = 8'h80; end
        if (t == 1) begin qa[t] = 8'h7F; qb[t] = 8'h80; end
        qv[t] = gaps ? (lfsr[3] | (t < 2)) : 1'b1;
        mult_a = qa[t]; mult_b = qb[t]; in_valid = qv[t];
      end else begin
        in_valid = 1'b0; mult_a = 8'h55; mult_b = 8'hAA;
      end
    end
  endtask

  // R5: reset with work in flight
  task automatic test_mid_reset();
    bit stayed_low = 1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      mult_a = 8'(t + 3); mult_b = 8'(t + 9); in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R5", "out_valid during reset", out_valid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT + 2) begin
      @(negedge clk);
      if (out_valid) stayed_low = 0;
    end
    chk(stayed_low, "R5", "flushed work never valid", !stayed_low, 0);
  endtask

  initial begin
    test_reset();
    test_corners();
    run_stream(40, 1'b0);
    run_stream(40, 1'b1);
    test_mid_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule